// File: doc/BRIEF.md
# CPU Clock Source Selector

This block chooses which of several free-running clocks drives the processor core and switches between them without producing a short pulse on the output. Seven clock inputs come in: a ring oscillator, a sub oscillator, a main oscillator, two phase-locked-loop products and two spread-spectrum products. The spread-spectrum path runs through a post-scaler that divides by 1, 2, 4 or 6. Every physical lane also brings a valid flag. Software asks for a source by writing a four-bit code. The block then reports the code that is really in use, raises a busy flag while a change is in progress, and raises a sticky fault flag if the source in use is lost.

The choice does not always come from software. Reset brings the core up on the ring oscillator. A normal wake-up from a power-save state moves the core to the main oscillator. A wake-up from the deep sub-clock state moves it to the ring or the sub oscillator, depending on a preset bit that software writes beforehand. A switch first waits for the new source's valid flag. It then turns the old lane off on that lane's falling edge. Only after the old lane is confirmed off does it arm the new lane, and the new lane opens after synchronising edges in its own domain.

All control logic runs on a configuration clock. Every clock lane has its own gate cell.

Top module: `cpu_clk_sel`

## Requirements
- R1: While reset is held and just after it, `act_code` is 0 (ring) and `fault` is 0. Once `busy` falls, `cpu_clk` runs at the ring-oscillator period.
- R2: Writing code 0 ring, 1 sub, 2 main, 3 PLL×4 or 4 PLL×8 with that lane valid ends with `busy` low, `act_code` equal to the code, and `cpu_clk` at that input's period.
- R3: Codes 5 to 9 select the spread-spectrum lane. Code 5 is the ×12 input divided by 6, code 6 is ×16 divided by 4, code 7 is ×12 divided by 2, code 8 is ×16 divided by 2 and code 9 is ×12 divided by 1. The resulting `cpu_clk` period is the input period times the divide ratio.
- R4: Writes of codes 10 to 15 are ignored: `busy` stays 0, and both `act_code` and the `cpu_clk` period are unchanged.
- R5: While the requested lane's valid flag (`src_ok` bit order: ring, sub, main, PLL×4, PLL×8, spread) is low, `busy` stays 1 and `act_code` keeps the old code. The switch completes once the flag rises.
- R6: `cpu_clk` never shows a high or low phase shorter than the shortest legal half period, and at most one lane gate is open at any time.
- R7: A write accepted while busy is held (the latest one wins) and is carried out after the switch in progress ends.
- R8: A wake event with `wake_sub` = 0 switches to code 2 (main).
- R9: A wake event with `wake_sub` = 1 switches to code 1 if the preset bit written through `pre_we`/`pre_sub` is 1, and to code 0 otherwise.
- R10: If the valid flag of the active non-ring lane drops, the block falls back to code 0 and sets `fault`, which stays set until reset.
- R11: `busy` is high in the cycle after a legal code is written while idle, and `act_code` only changes in a cycle that follows a busy cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cfg_clk | input | 1 | Control clock for the select, preset and status logic |
| rst_n | input | 1 | Active-low asynchronous reset |
| ring_clk | input | 1 | Ring-oscillator clock |
| sub_clk | input | 1 | Sub-oscillator clock |
| main_clk | input | 1 | Main-oscillator clock |
| pll4_clk | input | 1 | PLL ×4 product |
| pll8_clk | input | 1 | PLL ×8 product |
| ssc12_clk | input | 1 | Spread-spectrum ×12 product |
| ssc16_clk | input | 1 | Spread-spectrum ×16 product |
| src_ok | input | 6 | Valid flags per lane: ring, sub, main, PLL×4, PLL×8, spread |
| sel_we | input | 1 | Strobe for a source request |
| sel_code | input | 4 | Requested source code |
| pre_we | input | 1 | Strobe for the deep-wake preset bit |
| pre_sub | input | 1 | Preset: 1 means sub oscillator, 0 means ring |
| wake_evt | input | 1 | One-cycle power-save exit event |
| wake_sub | input | 1 | Exit kind: 1 for deep sub-clock exit |
| cpu_clk | output | 1 | Selected core clock |
| act_code | output | 4 | Code of the source in use |
| busy | output | 1 | A switch is in progress or pending |
| fault | output | 1 | Sticky loss-of-source flag |

## Verification
On every control-clock cycle the assertions check that busy follows an accepted write, that the reported code moves only after a busy cycle and never leaves the legal range, that the fault flag never clears, and that no two lane gates are open at once. The bench scenarios cover what needs timing or sequencing: the real output period for each code (and so the divide ratios), the lack of runt pulses across every ordered pair of sources, the choice of source on each kind of wake-up, the wait for a valid flag, the holding of a queued request, and the fallback after a source is lost.

// File: rtl/cksel_pkg.sv
`timescale 1ns/1ps
package cksel_pkg;
   localparam int CODE_W = 4;
   localparam int NLANE  = 6;
   localparam int NCODE  = 10;

   localparam logic [CODE_W-1:0] CODE_RING = 4'd0;
   localparam logic [CODE_W-1:0] CODE_SUB  = 4'd1;
   localparam logic [CODE_W-1:0] CODE_MAIN = 4'd2;

   typedef enum logic [2:0] {
      LN_RING = 3'd0, LN_SUB = 3'd1, LN_MAIN = 3'd2,
      LN_PLL4 = 3'd3, LN_PLL8 = 3'd4, LN_SSC  = 3'd5
   } lane_e;

   typedef enum logic [1:0] {PS_1, PS_2, PS_4, PS_6} pscale_e;

   typedef enum logic [1:0] {ST_IDLE, ST_WAITOK, ST_DRAIN, ST_START} sw_st_e;

   function automatic logic code_legal(logic [CODE_W-1:0] c);
      return int'(c) < NCODE;
   endfunction

   function automatic lane_e lane_of(logic [CODE_W-1:0] c);
      case (c)
         4'd0:    return LN_RING;
         4'd1:    return LN_SUB;
         4'd2:    return LN_MAIN;
         4'd3:    return LN_PLL4;
         4'd4:    return LN_PLL8;
         default: return LN_SSC;
      endcase
   endfunction

   function automatic logic mult16_of(logic [CODE_W-1:0] c);
      return (c == 4'd6) || (c == 4'd8);
   endfunction

   function automatic pscale_e ps_of(logic [CODE_W-1:0] c);
      case (c)
         4'd5:    return PS_6;
         4'd6:    return PS_4;
         4'd7:    return PS_2;
         4'd8:    return PS_2;
         default: return PS_1;
      endcase
   endfunction
endpackage

// File: rtl/cksel_sync.sv
`timescale 1ns/1ps
module cksel_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic arst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] sh;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) sh <= '0;
      else         sh <= {sh[STAGES-2:0], d};
   end

   assign q = sh[STAGES-1];
endmodule

// File: rtl/cksel_lane.sv
`timescale 1ns/1ps
module cksel_lane #(
   parameter int STAGES = 2
) (
   input  logic cfg_clk,
   input  logic rst_n,
   input  logic lane_clk,
   input  logic kill,
   input  logic en,
   output logic gclk,
   output logic gate,
   output logic ack
);
   logic arst_n;
   logic en_s;

   assign arst_n = rst_n & ~kill;

   // enable crosses into the lane domain on rising edges
   cksel_sync #(.STAGES(STAGES)) u_en_sync (
      .clk(lane_clk), .arst_n(arst_n), .d(en), .q(en_s)
   );

   // gate only moves while the lane clock is low
   always_ff @(negedge lane_clk or negedge arst_n) begin
      if (!arst_n) gate <= 1'b0;
      else         gate <= en_s;
   end

   assign gclk = lane_clk & gate;

   // gate state reported back to the control domain
   cksel_sync #(.STAGES(STAGES)) u_ack_sync (
      .clk(cfg_clk), .arst_n(rst_n), .d(gate), .q(ack)
   );
endmodule

// File: rtl/cksel_postscale.sv
`timescale 1ns/1ps
module cksel_postscale
   import cksel_pkg::*;
(
   input  logic    rst_n,
   input  logic    c12,
   input  logic    c16,
   input  logic    mult16,
   input  pscale_e ps,
   output logic    sclk
);
   logic       mclk;
   logic [1:0] lim;
   logic [1:0] cnt;
   logic       div;

   assign mclk = mult16 ? c16 : c12;

   always_comb begin
      case (ps)
         PS_2:    lim = 2'd0;
         PS_4:    lim = 2'd1;
         PS_6:    lim = 2'd2;
         default: lim = 2'd0;
      endcase
   end

   always_ff @(posedge mclk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         div <= 1'b0;
      end else if (cnt >= lim) begin
         cnt <= '0;
         div <= ~div;
      end else begin
         cnt <= cnt + 2'd1;
      end
   end

   assign sclk = (ps == PS_1) ? mclk : div;
endmodule

// File: rtl/cksel_ctrl.sv
`timescale 1ns/1ps
module cksel_ctrl
   import cksel_pkg::*;
#(
   parameter int CW = CODE_W,
   parameter int NL = NLANE
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sel_we,
   input  logic [CW-1:0] sel_code,
   input  logic          pre_we,
   input  logic          pre_sub,
   input  logic          wake_evt,
   input  logic          wake_sub,
   input  logic [NL-1:0] src_ok,
   input  logic [NL-1:0] ack,
   output logic [NL-1:0] en,
   output logic [NL-1:0] kill,
   output logic          mult16,
   output pscale_e       ps,
   output logic [CW-1:0] act_code,
   output logic          busy,
   output logic          fault
);
   sw_st_e        st;
   logic [CW-1:0] tgt;
   logic [CW-1:0] hold;
   logic          hold_vld;
   logic          pre_r;
   logic          req_vld;
   logic [CW-1:0] req_code;
   lane_e         cur_ln;
   lane_e         tgt_ln;

   assign cur_ln = lane_of(act_code);
   assign tgt_ln = lane_of(tgt);
   assign busy   = (st != ST_IDLE) | hold_vld;

   // wake-up events outrank software requests
   always_comb begin
      req_vld  = 1'b0;
      req_code = CODE_RING;
      if (wake_evt) begin
         req_vld  = 1'b1;
         req_code = wake_sub ? (pre_r ? CODE_SUB : CODE_RING) : CODE_MAIN;
      end else if (sel_we && code_legal(sel_code)) begin
         req_vld  = 1'b1;
         req_code = sel_code;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_START;
         act_code <= CODE_RING;
         tgt      <= CODE_RING;
         en       <= NL'(1);
         kill     <= '0;
         hold     <= CODE_RING;
         hold_vld <= 1'b0;
         pre_r    <= 1'b0;
         fault    <= 1'b0;
         mult16   <= 1'b0;
         ps       <= PS_1;
      end else begin
         if (pre_we) pre_r <= pre_sub;
         if (req_vld) begin
            hold     <= req_code;
            hold_vld <= 1'b1;
         end
         case (st)
            ST_IDLE: begin
               if (cur_ln != LN_RING && !src_ok[cur_ln]) begin
                  kill[cur_ln] <= 1'b1;
                  en[cur_ln]   <= 1'b0;
                  fault        <= 1'b1;
                  tgt          <= CODE_RING;
                  st           <= ST_WAITOK;
               end else if (hold_vld) begin
                  tgt <= hold;
                  if (!req_vld) hold_vld <= 1'b0;
                  st  <= ST_WAITOK;
               end
            end
            ST_WAITOK: begin
               if (src_ok[tgt_ln]) begin
                  en[cur_ln] <= 1'b0;
                  st         <= ST_DRAIN;
               end
            end
            ST_DRAIN: begin
               if (!ack[cur_ln]) begin
                  kill       <= '0;
                  mult16     <= mult16_of(tgt);
                  ps         <= ps_of(tgt);
                  en[tgt_ln] <= 1'b1;
                  st         <= ST_START;
               end
            end
            ST_START: begin
               if (ack[tgt_ln]) begin
                  act_code <= tgt;
                  st       <= ST_IDLE;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/cpu_clk_sel.sv
`timescale 1ns/1ps
module cpu_clk_sel
   import cksel_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic              cfg_clk,
   input  logic              rst_n,
   input  logic              ring_clk,
   input  logic              sub_clk,
   input  logic              main_clk,
   input  logic              pll4_clk,
   input  logic              pll8_clk,
   input  logic              ssc12_clk,
   input  logic              ssc16_clk,
   input  logic [NLANE-1:0]  src_ok,
   input  logic              sel_we,
   input  logic [CODE_W-1:0] sel_code,
   input  logic              pre_we,
   input  logic              pre_sub,
   input  logic              wake_evt,
   input  logic              wake_sub,
   output logic              cpu_clk,
   output logic [CODE_W-1:0] act_code,
   output logic              busy,
   output logic              fault
);
   localparam int LANES = NLANE;

   initial begin
      assert (SYNC_STAGES >= 2)
         else $fatal(1, "cpu_clk_sel: SYNC_STAGES must be at least 2");
   end

   logic [LANES-1:0] lane_clk;
   logic [LANES-1:0] lane_gclk;
   logic [LANES-1:0] lane_gate;
   logic [LANES-1:0] lane_ack;
   logic [LANES-1:0] lane_en;
   logic [LANES-1:0] lane_kill;
   logic             ssc_mult16;
   pscale_e          ssc_ps;
   logic             ssc_clk;

   cksel_postscale u_post (
      .rst_n  (rst_n),
      .c12    (ssc12_clk),
      .c16    (ssc16_clk),
      .mult16 (ssc_mult16),
      .ps     (ssc_ps),
      .sclk   (ssc_clk)
   );

   assign lane_clk[LN_RING] = ring_clk;
   assign lane_clk[LN_SUB]  = sub_clk;
   assign lane_clk[LN_MAIN] = main_clk;
   assign lane_clk[LN_PLL4] = pll4_clk;
   assign lane_clk[LN_PLL8] = pll8_clk;
   assign lane_clk[LN_SSC]  = ssc_clk;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      cksel_lane #(.STAGES(SYNC_STAGES)) u_lane (
         .cfg_clk  (cfg_clk),
         .rst_n    (rst_n),
         .lane_clk (lane_clk[g]),
         .kill     (lane_kill[g]),
         .en       (lane_en[g]),
         .gclk     (lane_gclk[g]),
         .gate     (lane_gate[g]),
         .ack      (lane_ack[g])
      );
   end

   assign cpu_clk = |lane_gclk;

   cksel_ctrl #(.CW(CODE_W), .NL(LANES)) u_ctrl (
      .clk      (cfg_clk),
      .rst_n    (rst_n),
      .sel_we   (sel_we),
      .sel_code (sel_code),
      .pre_we   (pre_we),
      .pre_sub  (pre_sub),
      .wake_evt (wake_evt),
      .wake_sub (wake_sub),
      .src_ok   (src_ok),
      .ack      (lane_ack),
      .en       (lane_en),
      .kill     (lane_kill),
      .mult16   (ssc_mult16),
      .ps       (ssc_ps),
      .act_code (act_code),
      .busy     (busy),
      .fault    (fault)
   );
endmodule

// File: rtl/cpu_clk_sel_chk.sv
`timescale 1ns/1ps
module cpu_clk_sel_chk
   import cksel_pkg::*;
(
   input logic              cfg_clk,
   input logic              rst_n,
   input logic              sel_we,
   input logic [CODE_W-1:0] sel_code,
   input logic              busy,
   input logic [CODE_W-1:0] act_code,
   input logic              fault,
   input logic [NLANE-1:0]  gate
);
   assert_busy_after_write_R11: assert property (@(posedge cfg_clk) disable iff (!rst_n)
      (sel_we && code_legal(sel_code) && !busy) |=> busy);

   assert_code_moves_after_busy_R11: assert property (@(posedge cfg_clk) disable iff (!rst_n)
      !$stable(act_code) |-> $past(busy));

   assert_code_legal_R4: assert property (@(posedge cfg_clk) disable iff (!rst_n)
      code_legal(act_code));

   assert_fault_sticky_R10: assert property (@(posedge cfg_clk) disable iff (!rst_n)
      $past(fault) |-> fault);

   assert_single_gate_R6: assert property (@(posedge cfg_clk) disable iff (!rst_n)
      $onehot0(gate));
endmodule

bind cpu_clk_sel cpu_clk_sel_chk u_chk (
   .cfg_clk  (cfg_clk),
   .rst_n    (rst_n),
   .sel_we   (sel_we),
   .sel_code (sel_code),
   .busy     (busy),
   .act_code (act_code),
   .fault    (fault),
   .gate     (lane_gate)
);

// File: tb/cpu_clk_sel_test.sv
`timescale 1ns/1ps
module cpu_clk_sel_test;
   logic       cfg_clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ring_clk = 1'b0, sub_clk = 1'b0, main_clk = 1'b0, pll4_clk = 1'b0;
   logic       pll8_clk = 1'b0, ssc12_clk = 1'b0, ssc16_clk = 1'b0;
   logic       run_pll8 = 1'b1;
   logic [5:0] src_ok = 6'b111111;
   logic       sel_we = 1'b0;
   logic [3:0] sel_code = 4'd0;
   logic       pre_we = 1'b0, pre_sub = 1'b0;
   logic       wake_evt = 1'b0, wake_sub = 1'b0;
   logic       cpu_clk;
   logic [3:0] act_code;
   logic       busy, fault;

   int  n_run = 0;
   int  n_fail = 0;
   int  runts = 0;
   bit  mon_on = 1'b0;
   bit  seen2 = 1'b0;
   real last_edge = 0.0;

   always #5  cfg_clk   = ~cfg_clk;
   always #17 ring_clk  = ~ring_clk;
   always #29 sub_clk   = ~sub_clk;
   always #13 main_clk  = ~main_clk;
   always #7  pll4_clk  = ~pll4_clk;
   always #3  ssc12_clk = ~ssc12_clk;
   always #2  ssc16_clk = ~ssc16_clk;
   initial forever begin
      #4;
      if (run_pll8) pll8_clk = ~pll8_clk;
   end

   cpu_clk_sel uut (
      .cfg_clk(cfg_clk), .rst_n(rst_n),
      .ring_clk(ring_clk), .sub_clk(sub_clk), .main_clk(main_clk),
      .pll4_clk(pll4_clk), .pll8_clk(pll8_clk),
      .ssc12_clk(ssc12_clk), .ssc16_clk(ssc16_clk),
      .src_ok(src_ok), .sel_we(sel_we), .sel_code(sel_code),
      .pre_we(pre_we), .pre_sub(pre_sub),
      .wake_evt(wake_evt), .wake_sub(wake_sub),
      .cpu_clk(cpu_clk), .act_code(act_code), .busy(busy), .fault(fault)
   );

   // R6 runt monitor: shortest legal phase is 3 ns
   always @(cpu_clk) begin
      if (mon_on && ($realtime - last_edge) < 2.9) runts++;
      last_edge = $realtime;
   end

   always @(negedge cfg_clk) if (act_code == 4'd2) seen2 = 1'b1;

   function automatic real exp_period(int code);
      real inp;
      int  ratio;
      case (code)
         0: return 34.0;
         1: return 58.0;
         2: return 26.0;
         3: return 14.0;
         4: return 8.0;
         default: begin
            inp = (code == 6 || code == 8) ? 4.0 : 6.0;
            case (code)
               5: ratio = 6;
               6: ratio = 4;
               7: ratio = 2;
               8: ratio = 2;
               default: ratio = 1;
            endcase
            return inp * ratio;
         end
      endcase
   endfunction

   task automatic chk(string tag, int got, int exp);
      n_run++;
      if (got != exp) begin
         n_fail++;
         $display("FAIL %s: got %0d expected %0d", tag, got, exp);
      end
   endtask

   task automatic chk_per(string tag, real got, real exp);
      n_run++;
      if (got < exp - 0.01 || got > exp + 0.01) begin
         n_fail++;
         $display("FAIL %s: period got %0.3f expected %0.3f", tag, got, exp);
      end
   endtask

   task automatic measure(output real p);
      real t0;
      @(posedge cpu_clk);
      @(posedge cpu_clk);
      t0 = $realtime;
      @(posedge cpu_clk);
      p = $realtime - t0;
   endtask

   task automatic wait_idle();
      repeat (2) @(negedge cfg_clk);
      while (busy) @(negedge cfg_clk);
   endtask

   task automatic write_sel(int code);
      @(negedge cfg_clk);
      sel_we = 1'b1;
      sel_code = 4'(code);
      @(negedge cfg_clk);
      sel_we = 1'b0;
   endtask

   task automatic switch_to(int code);
      write_sel(code);
      wait_idle();
   endtask

   task automatic wake(bit sub);
      @(negedge cfg_clk);
      wake_evt = 1'b1;
      wake_sub = sub;
      @(negedge cfg_clk);
      wake_evt = 1'b0;
      wait_idle();
   endtask

   task automatic preset(bit sub);
      @(negedge cfg_clk);
      pre_we = 1'b1;
      pre_sub = sub;
      @(negedge cfg_clk);
      pre_we = 1'b0;
   endtask

   initial begin
      #1_000_000;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      real p;
      repeat (3) @(negedge cfg_clk);
      chk("R1 reset code", int'(act_code), 0);
      chk("R1 reset fault", int'(fault), 0);
      rst_n = 1'b1;
      wait_idle();
      mon_on = 1'b1;
      chk("R1 code after reset", int'(act_code), 0);
      measure(p);
      chk_per("R1 ring period", p, 34.0);

      // R2 / R3: every ordered pair of sources
      for (int a = 0; a < 10; a++) begin
         for (int b = 0; b < 10; b++) begin
            switch_to(a);
            switch_to(b);
            chk((b < 5) ? "R2 code" : "R3 code", int'(act_code), b);
            measure(p);
            chk_per((b < 5) ? "R2 period" : "R3 period", p, exp_period(b));
         end
      end

      // R4: illegal codes ignored
      switch_to(3);
      for (int c = 10; c < 16; c++) begin
         write_sel(c);
         repeat (3) @(negedge cfg_clk);
         chk("R4 busy", int'(busy), 0);
         chk("R4 code", int'(act_code), 3);
      end
      measure(p);
      chk_per("R4 period", p, 14.0);

      // R5: wait for valid flag
      src_ok[4] = 1'b0;
      write_sel(4);
      repeat (20) @(negedge cfg_clk);
      chk("R5 busy while invalid", int'(busy), 1);
      chk("R5 code held", int'(act_code), 3);
      src_ok[4] = 1'b1;
      wait_idle();
      chk("R5 code after valid", int'(act_code), 4);

      // R7: request during a switch
      switch_to(0);
      seen2 = 1'b0;
      @(negedge cfg_clk);
      sel_we = 1'b1; sel_code = 4'd2;
      @(negedge cfg_clk);
      sel_code = 4'd1;
      @(negedge cfg_clk);
      sel_we = 1'b0;
      wait_idle();
      chk("R7 queued code", int'(act_code), 1);
      chk("R7 first switch done", int'(seen2), 1);

      // R8: normal wake -> main
      switch_to(4);
      wake(1'b0);
      chk("R8 wake code", int'(act_code), 2);
      measure(p);
      chk_per("R8 wake period", p, 26.0);

      // R9: deep wake -> preset
      preset(1'b1);
      switch_to(9);
      wake(1'b1);
      chk("R9 wake to sub", int'(act_code), 1);
      measure(p);
      chk_per("R9 sub period", p, 58.0);
      preset(1'b0);
      switch_to(5);
      wake(1'b1);
      chk("R9 wake to ring", int'(act_code), 0);

      // R10: loss of active source
      switch_to(4);
      chk("R10 fault clear before", int'(fault), 0);
      @(negedge pll8_clk);
      run_pll8 = 1'b0;
      @(negedge cfg_clk);
      src_ok[4] = 1'b0;
      wait_idle();
      chk("R10 fallback code", int'(act_code), 0);
      chk("R10 fault set", int'(fault), 1);
      measure(p);
      chk_per("R10 fallback period", p, 34.0);
      run_pll8 = 1'b1;
      src_ok[4] = 1'b1;
      switch_to(3);
      chk("R10 fault sticky", int'(fault), 1);
      chk("R10 new code", int'(act_code), 3);

      chk("R6 runt pulses", runts, 0);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule